// File: doc/BRIEF.md
# Sub-word Memory Slave with Byte-Lane Write Enables

This block is a single-port memory that sits on a 32-bit pipelined system bus of the AHB-Lite kind. It answers byte, halfword and word transfers. Select, transfer type, direction, size and address are captured in the address phase. The access itself happens in the following data phase. The transfer size and the two lowest address bits give a four-bit mask of active byte lanes. On a write, that mask serves as a per-byte write enable, so a narrow write changes only its own bytes of the stored word. On a read, the whole addressed word is returned, and the caller keeps only the active lanes.

A request that is not naturally aligned, or that asks for more than a word, is answered with a two-cycle error and leaves storage alone. Valid transfers complete with zero wait states.

The control is a four-state machine:
- `PH_IDLE`: no data phase is pending.
- `PH_XFER`: a valid data phase is in progress.
- `PH_ERR_HOLD`: first error cycle, with ready low.
- `PH_ERR_DONE`: second error cycle, with ready high.

It moves between these states as follows:
- From `PH_IDLE`, `PH_XFER` or `PH_ERR_DONE`, an accepted aligned request leads to `PH_XFER`.
- From the same three states, an accepted faulty request leads to `PH_ERR_HOLD`.
- From the same three states, no accepted request leads to `PH_IDLE`.
- `PH_ERR_HOLD` always moves to `PH_ERR_DONE`.

Top module: `subword_mem_slave`

## Requirements
- R1: A byte transfer (size 3'b000) activates exactly one lane, the lane whose number equals addr[1:0]. Lane n covers bits [8n+7:8n].
- R2: A halfword transfer (size 3'b001) activates lanes 0 and 1 when addr[1]=0, and lanes 2 and 3 when addr[1]=1.
- R3: A word transfer (size 3'b010) at addr[1:0]=00 activates all four lanes.
- R4: A write updates only the bytes of active lanes. Every other byte of the stored word keeps its previous value, whatever `wdata` carries in that lane.
- R5: An accepted aligned read drives the full addressed word on `rdata` in the next cycle, with `ready_out`=1 and `resp`=0. In every other cycle `rdata` is zero.
- R6: A request is accepted only when `sel`=1, `ready_in`=1 and `trans` is 2'b10 or 2'b11. Transfers of type 2'b00 or 2'b01, deselected transfers and transfers while `ready_in`=0 change nothing.
- R7: Any of the following is a faulty request: a halfword with addr[0]=1, a word with addr[1:0]≠00, or any size above 3'b010. It gets `ready_out`=0 and `resp`=1 in the first cycle after acceptance, then `ready_out`=1 and `resp`=1 in the second cycle. Storage is not modified.
- R8: Write data is taken from `wdata` in the data phase that follows the accepted address phase, not in the address phase.
- R9: After reset, `ready_out`=1, `resp`=0, `rdata`=0 and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Slave select for the current address phase |
| addr | input | ADDR_W | Byte address of the current address phase |
| trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| write | input | 1 | 1 for a write, 0 for a read |
| size | input | 3 | Transfer size: 000 byte, 001 halfword, 010 word |
| wdata | input | DATA_W | Write data of the current data phase |
| ready_in | input | 1 | Combined bus ready; an address phase is taken only when high |
| rdata | output | DATA_W | Read data of the current data phase |
| ready_out | output | 1 | Slave ready; low only in the first error cycle |
| resp | output | 1 | 1 for an error response, 0 for OKAY |

## Verification
The assertions assume that `ready_in` is the bus-wide ready, which includes this slave's own `ready_out`. No address phase can therefore be accepted while the block holds the first error cycle. They also assume that reset is applied before the first access. The bench ties `ready_in` to `ready_out` AND a second ready that stands in for another slave. That second ready is lowered only when no data phase of this block is pending, so the stimulus never asks the block to stretch a valid transfer it cannot stretch.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_HALF = 3'b001;
    localparam logic [2:0] SZ_WORD = 3'b010;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_XFER     = 2'd1,
        PH_ERR_HOLD = 2'd2,
        PH_ERR_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/sws_lane_decode.sv
module sws_lane_decode #(
    parameter int LANES = 4,
    parameter int OFS_W = $clog2(LANES)
) (
    input  logic [2:0]       size,
    input  logic [OFS_W-1:0] offset,
    output logic [LANES-1:0] lane_en,
    output logic             fault
);
    localparam logic [2:0] MAX_SZ = 3'(OFS_W);

    logic too_big;
    int   ofs_i;
    int   sz_i;

    assign too_big = (size > MAX_SZ);
    assign ofs_i   = int'(offset);
    assign sz_i    = int'(size);

    // A transfer of 2**size bytes covers the lanes that share its offset above bit size.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !too_big && ((g >> sz_i) == (ofs_i >> sz_i));
    end

    assign fault = too_big || ((ofs_i & ((1 << sz_i) - 1)) != 0);

endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
    import sws_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   bad,
    output phase_e state,
    output logic   ready_out,
    output logic   resp
);
    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = PH_IDLE;
        unique case (state_q)
            PH_ERR_HOLD: state_d = PH_ERR_DONE;
            PH_IDLE, PH_XFER, PH_ERR_DONE: begin
                if (accept) state_d = bad ? PH_ERR_HOLD : PH_XFER;
                else        state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        ready_out = 1'b1;
        resp      = 1'b0;
        unique case (state_q)
            PH_ERR_HOLD: begin ready_out = 1'b0; resp = 1'b1; end
            PH_ERR_DONE: begin ready_out = 1'b1; resp = 1'b1; end
            PH_IDLE, PH_XFER: begin ready_out = 1'b1; resp = 1'b0; end
            default: begin ready_out = 1'b1; resp = 1'b0; end
        endcase
    end

    assign state = state_q;

    // R7: the first error cycle is always followed by the second
    a_r7_hold_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ERR_HOLD) |=> (state_q == PH_ERR_DONE));

endmodule

// File: rtl/sws_store.sv
module sws_store #(
    parameter int LANES = 4,
    parameter int IDX_W = 6,
    parameter int WORDS = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [LANES-1:0]     lane_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [8*LANES-1:0]   wdata,
    output logic [8*LANES-1:0]   word
);
    // One byte bank per lane; a lane's bank is written only when its enable is set.
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [7:0] bank [WORDS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) bank[w] <= 8'h00;
            end else if (we && lane_en[g]) begin
                bank[idx] <= wdata[8*g +: 8];
            end
        end

        assign word[8*g +: 8] = bank[idx];
    end

endmodule

// File: rtl/subword_mem_slave.sv
module subword_mem_slave
    import sws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        trans,
    input  logic              write,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready_in,
    output logic [DATA_W-1:0] rdata,
    output logic              ready_out,
    output logic              resp
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic             accept;
    logic             live_fault;
    logic [LANES-1:0] live_lanes;
    logic [LANES-1:0] cap_lanes;
    logic             cap_fault;
    phase_e           state;

    logic             cap_write;
    logic [2:0]       cap_size;
    logic [OFS_W-1:0] cap_ofs;
    logic [IDX_W-1:0] cap_idx;

    logic             store_we;
    logic [DATA_W-1:0] store_word;

    assign accept = sel && ready_in && ((trans == TR_NONSEQ) || (trans == TR_SEQ));

    // Fault check on the live request picks the next state.
    sws_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_live_dec (
        .size    (size),
        .offset  (addr[OFS_W-1:0]),
        .lane_en (live_lanes),
        .fault   (live_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_size  <= SZ_BYTE;
            cap_ofs   <= '0;
            cap_idx   <= '0;
        end else if (accept) begin
            cap_write <= write;
            cap_size  <= size;
            cap_ofs   <= addr[OFS_W-1:0];
            cap_idx   <= addr[ADDR_W-1:OFS_W];
        end
    end

    // Lane mask of the data phase comes from the registered size and offset.
    sws_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_cap_dec (
        .size    (cap_size),
        .offset  (cap_ofs),
        .lane_en (cap_lanes),
        .fault   (cap_fault)
    );

    sws_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .bad       (live_fault),
        .state     (state),
        .ready_out (ready_out),
        .resp      (resp)
    );

    assign store_we = (state == PH_XFER) && cap_write;

    sws_store #(.LANES(LANES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .lane_en (cap_lanes),
        .idx     (cap_idx),
        .wdata   (wdata),
        .word    (store_word)
    );

    assign rdata = ((state == PH_XFER) && !cap_write) ? store_word : '0;

    // R7: second error cycle follows the first with ready high, error kept
    a_r7_err_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_out |=> (ready_out && resp));
    // R7: ready is never low without an error response
    a_r7_low_ready_is_err: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_out |-> resp);
    // R7: storage is not written while an error is signalled
    a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        resp |-> !store_we);
    // R5: a valid data phase completes OKAY without wait states
    a_r5_xfer_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_XFER) |-> (ready_out && !resp && !cap_fault));
    // R1: a byte data phase drives exactly one lane
    a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_XFER && cap_size == SZ_BYTE) |-> $countones(cap_lanes) == 1);
    // R2: a halfword data phase drives an aligned lane pair
    a_r2_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_XFER && cap_size == SZ_HALF) |->
            (cap_lanes == 4'b0011 || cap_lanes == 4'b1100));
    // R3: a word data phase drives every lane
    a_r3_word_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_XFER && cap_size == SZ_WORD) |-> (&cap_lanes));
    // R6: nothing is captured while the bus ready is low
    a_r6_hold_when_unready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_in |=> ($stable(cap_idx) && $stable(cap_size) && $stable(cap_write)));

endmodule

// File: tb/subword_mem_slave_test.sv
module subword_mem_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  trans = 2'b00;
    logic        write = 1'b0;
    logic [2:0]  size = 3'b000;
    logic [31:0] wdata = '0;
    logic        oth_rdy = 1'b1;
    logic        ready_in;
    logic [31:0] rdata;
    logic        ready_out;
    logic        resp;

    int errors = 0;
    int checks = 0;
    logic [31:0] pend_wd = '0;

    // reference model state
    logic [31:0] ref_mem [WORDS];
    int          ph = 0;          // 0 none, 1 transfer, 2 first error, 3 second error
    logic        ph_wr = 1'b0;
    logic [2:0]  ph_sz = '0;
    logic [7:0]  ph_a = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ready_in = ready_out & oth_rdy;

    subword_mem_slave uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .trans(trans),
        .write(write), .size(size), .wdata(wdata), .ready_in(ready_in),
        .rdata(rdata), .ready_out(ready_out), .resp(resp)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_lanes(input logic [2:0] s, input logic [1:0] o);
        if (s == 3'b000) return 4'b0001 << o;
        if (s == 3'b001) return o[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic bit ref_bad(input logic [2:0] s, input logic [1:0] o);
        return (s > 3'b010) || (s == 3'b001 && o[0]) || (s == 3'b010 && o != 2'b00);
    endfunction

    // model update at the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) ref_mem[w] = '0;
            ph = 0;
        end else begin
            bit rdy_now;
            rdy_now = (ph != 2);
            if (ph == 1 && ph_wr) begin
                logic [3:0] m;
                m = ref_lanes(ph_sz, ph_a[1:0]);
                for (int k = 0; k < 4; k++)
                    if (m[k]) ref_mem[ph_a[7:2]][8*k +: 8] = wdata[8*k +: 8];
            end
            if (ph == 2) ph = 3;
            else if (sel && rdy_now && oth_rdy && trans[1]) begin
                ph    = ref_bad(size, addr[1:0]) ? 2 : 1;
                ph_wr = write;
                ph_sz = size;
                ph_a  = addr;
            end else ph = 0;
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] exp_rd;
            string t;
            exp_rd = (ph == 1 && !ph_wr) ? ref_mem[ph_a[7:2]] : 32'h0;
            t = (ph >= 2) ? "R7" : ((ph == 1) ? "R5" : "R6");
            check(rdata == exp_rd, {t, " rdata"}, rdata, exp_rd);
            check(ready_out == (ph != 2), {t, " ready"}, 32'(ready_out), 32'(ph != 2));
            check(resp == (ph >= 2), {t, " resp"}, 32'(resp), 32'(ph >= 2));
        end
    end

    task automatic issue(input logic s, input logic [1:0] tr, input logic wr,
                         input logic [2:0] sz, input logic [7:0] a,
                         input logic [31:0] d, input logic orr);
        @(negedge clk);
        wdata   = pend_wd;
        pend_wd = d;
        sel = s; trans = tr; write = wr; size = sz; addr = a; oth_rdy = orr;
    endtask

    task automatic idle();
        issue(1'b0, 2'b00, 1'b0, 3'b000, 8'h00, 32'h0, 1'b1);
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        issue(1'b1, 2'b10, 1'b0, 3'b010, a, 32'h0, 1'b1);
        idle();
        check(rdata == exp, tag, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ready_out == 1'b1 && resp == 1'b0, "R9 reset ready/resp", {30'h0, ready_out, resp}, 32'h2);
        check(rdata == 32'h0, "R9 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        rd_check(8'h20, 32'h0, "R9 cleared word");

        // R3 word write, R8 data taken in data phase (read issued back to back)
        issue(1'b1, 2'b10, 1'b1, 3'b010, 8'h10, 32'h11223344, 1'b1);
        rd_check(8'h10, 32'h11223344, "R3 word write / R8 data phase");

        // R1 byte at lane 1, R4 other lanes carry junk
        issue(1'b1, 2'b10, 1'b1, 3'b000, 8'h11, 32'hFFFFAAFF, 1'b1);
        rd_check(8'h10, 32'h1122AA44, "R1 byte lane1 / R4 neighbours kept");
        issue(1'b1, 2'b11, 1'b1, 3'b000, 8'h13, 32'h77000055, 1'b1);
        rd_check(8'h10, 32'h7722AA44, "R1 byte lane3 / R4");

        // R2 upper and lower halfwords
        issue(1'b1, 2'b10, 1'b1, 3'b001, 8'h12, 32'hBEEF1234, 1'b1);
        rd_check(8'h10, 32'hBEEFAA44, "R2 upper half");
        issue(1'b1, 2'b10, 1'b1, 3'b001, 8'h14, 32'h9999CAFE, 1'b1);
        rd_check(8'h14, 32'h0000CAFE, "R2 lower half");

        // R7 misaligned halfword write
        issue(1'b1, 2'b10, 1'b1, 3'b001, 8'h11, 32'h55555555, 1'b1);
        idle();
        check(!ready_out && resp, "R7 first error cycle", {30'h0, ready_out, resp}, 32'h1);
        idle();
        check(ready_out && resp, "R7 second error cycle", {30'h0, ready_out, resp}, 32'h3);
        rd_check(8'h10, 32'hBEEFAA44, "R7 memory untouched");
        // R7 misaligned word, oversize
        issue(1'b1, 2'b10, 1'b1, 3'b010, 8'h16, 32'h0, 1'b1);
        idle(); idle();
        issue(1'b1, 2'b10, 1'b1, 3'b011, 8'h10, 32'h0, 1'b1);
        idle();
        check(!ready_out && resp, "R7 oversize error", {30'h0, ready_out, resp}, 32'h1);
        idle();
        rd_check(8'h10, 32'hBEEFAA44, "R7 oversize no write");
        rd_check(8'h14, 32'h0000CAFE, "R7 misaligned word no write");

        // R6 busy, deselected, unready
        issue(1'b1, 2'b01, 1'b1, 3'b010, 8'h10, 32'hFFFFFFFF, 1'b1);
        idle();
        issue(1'b0, 2'b10, 1'b1, 3'b010, 8'h10, 32'hFFFFFFFF, 1'b1);
        idle();
        issue(1'b1, 2'b10, 1'b1, 3'b010, 8'h10, 32'hFFFFFFFF, 1'b0);
        idle();
        rd_check(8'h10, 32'hBEEFAA44, "R6 ignored transfers");

        // mixed traffic checked cycle by cycle against the model
        for (int n = 0; n < 3000; n++) begin
            logic orr;
            orr = (ph == 0) ? ($urandom_range(0, 7) != 0) : 1'b1;
            issue(1'($urandom_range(0, 7) != 0), 2'($urandom), 1'($urandom),
                  3'($urandom_range(0, 4)), 8'($urandom_range(0, 31)), $urandom, orr);
        end
        idle(); idle(); idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule